// File: doc/BRIEF.md
# DMA Page Register Address Generator

This block keeps the two page bytes (a low page and a high page) for each of four DMA channels. From them and the channel's current 16-bit address it forms the full physical address of every transfer beat. Software reaches the page bytes through a byte-wide port interface. The 3-bit port offset does not name a channel directly. It goes through a sparse remap in which several offsets are holes. A separate window-select bit chooses between the low-page bank and the high-page bank.

The channel logic outside this block asks for a beat by giving the channel number, the channel's mode byte, its start address and the position of the beat within the transfer. One cycle later the block returns the physical address with a valid strobe. The address steps up or down through the 16-bit space as the mode's direction bit selects. It also raises a suppress flag when the mode names a verify transfer, so that the memory side makes no access while the beat still completes.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset every page byte of every channel reads as 0x00 in both windows, and `out_valid` is low.
- R2: The port offset `port_off` selects a channel as follows: offset 7 selects channel 0, offset 3 selects channel 1, offset 1 selects channel 2 and offset 2 selects channel 3.
- R3: A write to offset 0, 4, 5 or 6 changes no page byte in either window.
- R4: A read from offset 0, 4, 5 or 6 returns 0x00. `port_rdata` is also 0x00 whenever `port_rd` is low.
- R5: `port_hi` = 0 reaches the low-page byte and `port_hi` = 1 reaches the high-page byte. A write to one of them leaves the other unchanged.
- R6: The physical address has 31 bits. Bits 30:24 are bits 6:0 of the high page, so bit 7 of the high page is dropped. Bits 23:16 are the low page. Bits 15:0 are the beat's 16-bit offset address.
- R7: When bit 5 of `beat_mode` is 0, the 16-bit offset address is (`beat_base` + `beat_pos`) modulo 65536.
- R8: When bit 5 of `beat_mode` is 1, the 16-bit offset address is (`beat_base` − `beat_pos`) modulo 65536.
- R9: `out_suppress` is 1 on a returned beat exactly when bits 3:2 of that beat's `beat_mode` are 00. The beat is still returned with `out_valid` high. `out_suppress` is 0 whenever `out_valid` is 0.
- R10: `out_valid` is high in the cycle after a cycle with `beat_req` high, and low in the cycle after a cycle with `beat_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Write strobe for a page byte |
| port_rd | input | 1 | Read enable for a page byte |
| port_hi | input | 1 | Window select: 0 for the low page, 1 for the high page |
| port_off | input | 3 | Port offset, remapped to a channel |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data (combinational) |
| beat_req | input | 1 | Beat request |
| beat_chan | input | 2 | Channel of the beat |
| beat_mode | input | 8 | Channel mode byte (bit 5 selects direction, bits 3:2 select the transfer type) |
| beat_base | input | 16 | Channel's current start address |
| beat_pos | input | 16 | Position of the beat within the transfer |
| out_valid | output | 1 | Result valid strobe |
| out_phys | output | 31 | Physical address of the beat |
| out_suppress | output | 1 | Verify beat: make no memory access |

## Verification
Read data has no register on its path, so the bench samples it in the same cycle, a few nanoseconds after it drives the offset. A page write takes effect at the next rising edge, so the bench reads a page byte back only after that edge. A beat presented before one rising edge has its address, suppress flag and strobe at the outputs after that edge. The bench therefore drives every beat on a falling edge and checks the result on the following falling edge. Once a burst of back-to-back beats ends, it checks one more falling edge to confirm the strobe has dropped.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

    localparam int NUM_CHAN   = 4;
    localparam int CHAN_W     = 2;
    localparam int PAGE_W     = 8;
    localparam int OFS_W      = 16;
    localparam int HI_KEEP    = 7;
    localparam int PHYS_W     = OFS_W + PAGE_W + HI_KEEP;
    localparam int PORT_OFF_W = 3;

    localparam int MODE_DEC_BIT = 5;
    localparam int MODE_TYP_LO  = 2;

    typedef enum logic [1:0] {
        XFER_VERIFY = 2'b00,
        XFER_WRITE  = 2'b01,
        XFER_READ   = 2'b10,
        XFER_ILLEGAL = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        logic              hit;
        logic [CHAN_W-1:0] chan;
    } chan_sel_t;

    typedef struct packed {
        logic [HI_KEEP-1:0] hi;
        logic [PAGE_W-1:0]  lo;
        logic [OFS_W-1:0]   ofs;
    } phys_addr_t;

    typedef struct packed {
        logic       valid;
        phys_addr_t addr;
        logic       suppress;
    } beat_result_t;

    function automatic chan_sel_t decode_offset(input logic [PORT_OFF_W-1:0] off);
        chan_sel_t s;
        s.hit  = 1'b1;
        s.chan = '0;
        unique case (off)
            3'd1: s.chan = 2'd2;
            3'd2: s.chan = 2'd3;
            3'd3: s.chan = 2'd1;
            3'd7: s.chan = 2'd0;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

    function automatic xfer_kind_e mode_kind(input logic [7:0] mode);
        return xfer_kind_e'(mode[MODE_TYP_LO +: 2]);
    endfunction

    function automatic logic [OFS_W-1:0] step_offset(input logic [OFS_W-1:0] base,
                                                     input logic [OFS_W-1:0] pos,
                                                     input logic             dec);
        return dec ? (base - pos) : (base + pos);
    endfunction

endpackage

// File: rtl/dma_page_regs.sv
module dma_page_regs
    import dma_page_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              port_wr,
    input  logic                              port_rd,
    input  logic                              port_hi,
    input  logic [PORT_OFF_W-1:0]             port_off,
    input  logic [PAGE_W-1:0]                 port_wdata,
    output logic [PAGE_W-1:0]                 port_rdata,
    output logic [NUM_CHAN-1:0][PAGE_W-1:0]   lo_page,
    output logic [NUM_CHAN-1:0][PAGE_W-1:0]   hi_page
);

    chan_sel_t sel;
    logic [NUM_CHAN-1:0][PAGE_W-1:0] lo_q, hi_q;

    always_comb sel = decode_offset(port_off);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic hit_c;
        always_comb hit_c = port_wr && sel.hit && (sel.chan == CHAN_W'(c));
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[c] <= '0;
                hi_q[c] <= '0;
            end else if (hit_c) begin
                if (port_hi) hi_q[c] <= port_wdata;
                else         lo_q[c] <= port_wdata;
            end
        end
    end

    always_comb begin
        port_rdata = '0;
        if (port_rd && sel.hit)
            port_rdata = port_hi ? hi_q[sel.chan] : lo_q[sel.chan];
    end

    assign lo_page = lo_q;
    assign hi_page = hi_q;

    AST_BAD_OFFSET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (port_wr && !sel.hit) |=> ($stable(lo_q) && $stable(hi_q))); // R3
    AST_PAGE_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!port_wr) |=> ($stable(lo_q) && $stable(hi_q))); // R5
    AST_WINDOW_SEPARATE: assert property (@(posedge clk) disable iff (rst)
        (port_wr && port_hi) |=> $stable(lo_q)); // R5

endmodule

// File: rtl/dma_beat_addr.sv
module dma_beat_addr
    import dma_page_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CHAN-1:0][PAGE_W-1:0] lo_page,
    input  logic [NUM_CHAN-1:0][PAGE_W-1:0] hi_page,
    input  logic                            beat_req,
    input  logic [CHAN_W-1:0]               beat_chan,
    input  logic [7:0]                      beat_mode,
    input  logic [OFS_W-1:0]                beat_base,
    input  logic [OFS_W-1:0]                beat_pos,
    output beat_result_t                    result
);

    beat_result_t nxt, res_q;

    always_comb begin
        nxt.valid     = beat_req;
        nxt.addr.hi   = hi_page[beat_chan][HI_KEEP-1:0];
        nxt.addr.lo   = lo_page[beat_chan];
        nxt.addr.ofs  = step_offset(beat_base, beat_pos, beat_mode[MODE_DEC_BIT]);
        nxt.suppress  = beat_req && (mode_kind(beat_mode) == XFER_VERIFY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid    <= nxt.valid;
            res_q.suppress <= nxt.suppress;
            if (beat_req) res_q.addr <= nxt.addr;
        end
    end

    assign result = res_q;

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        beat_req |=> result.valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !beat_req |=> !result.valid); // R10
    AST_SUPPRESS_GATED: assert property (@(posedge clk) disable iff (rst)
        !result.valid |-> !result.suppress); // R9
    AST_VERIFY_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
        (beat_req && beat_mode[3:2] == 2'b00) |=> result.suppress); // R9

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dma_page_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  port_wr,
    input  logic                  port_rd,
    input  logic                  port_hi,
    input  logic [PORT_OFF_W-1:0] port_off,
    input  logic [PAGE_W-1:0]     port_wdata,
    output logic [PAGE_W-1:0]     port_rdata,
    input  logic                  beat_req,
    input  logic [CHAN_W-1:0]     beat_chan,
    input  logic [7:0]            beat_mode,
    input  logic [OFS_W-1:0]      beat_base,
    input  logic [OFS_W-1:0]      beat_pos,
    output logic                  out_valid,
    output logic [PHYS_W-1:0]     out_phys,
    output logic                  out_suppress
);

    logic [NUM_CHAN-1:0][PAGE_W-1:0] lo_page, hi_page;
    beat_result_t res;

    dma_page_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .port_wr    (port_wr),
        .port_rd    (port_rd),
        .port_hi    (port_hi),
        .port_off   (port_off),
        .port_wdata (port_wdata),
        .port_rdata (port_rdata),
        .lo_page    (lo_page),
        .hi_page    (hi_page)
    );

    dma_beat_addr u_beat (
        .clk       (clk),
        .rst       (rst),
        .lo_page   (lo_page),
        .hi_page   (hi_page),
        .beat_req  (beat_req),
        .beat_chan (beat_chan),
        .beat_mode (beat_mode),
        .beat_base (beat_base),
        .beat_pos  (beat_pos),
        .result    (res)
    );

    assign out_valid    = res.valid;
    assign out_phys     = res.addr;
    assign out_suppress = res.suppress;

endmodule

// File: tb/dma_page_addr_gen_test.sv
module dma_page_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_wr = 0, port_rd = 0, port_hi = 0;
    logic [2:0]  port_off = 0;
    logic [7:0]  port_wdata = 0;
    logic [7:0]  port_rdata;
    logic        beat_req = 0;
    logic [1:0]  beat_chan = 0;
    logic [7:0]  beat_mode = 0;
    logic [15:0] beat_base = 0, beat_pos = 0;
    logic        out_valid;
    logic [30:0] out_phys;
    logic        out_suppress;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [7:0] exp_lo [4];
    logic [7:0] exp_hi [4];

    always #10 clk = ~clk;

    dma_page_addr_gen uut (.*);

    function automatic int chan_of(input int off);
        case (off)
            1: return 2;
            2: return 3;
            3: return 1;
            7: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_page(input bit hi, input int off, input logic [7:0] d);
        @(negedge clk);
        port_wr = 1; port_hi = hi; port_off = 3'(off); port_wdata = d;
        @(negedge clk);
        port_wr = 0;
    endtask

    task automatic rd_page(input bit hi, input int off, output logic [7:0] d);
        @(negedge clk);
        port_rd = 1; port_hi = hi; port_off = 3'(off);
        #2 d = port_rdata;
        port_rd = 0;
    endtask

    task automatic check_all_pages(input string tag);
        logic [7:0] d;
        for (int h = 0; h < 2; h++) begin
            for (int off = 0; off < 8; off++) begin
                int c;
                logic [7:0] e;
                c = chan_of(off);
                e = (c < 0) ? 8'h00 : (h != 0 ? exp_hi[c] : exp_lo[c]);
                rd_page(h != 0, off, d);
                if (c < 0) check({tag, " R4 invalid read"}, d, e);
                else       check({tag, " R2 R5 page read"}, d, e);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin exp_lo[c] = 0; exp_hi[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 valid after reset", out_valid, 1'b0);
        check_all_pages("R1");

        // R4: rdata is zero when port_rd is low
        @(negedge clk);
        port_rd = 0; port_off = 3'd7; port_hi = 0;
        #2 check("R4 idle rdata", port_rdata, 8'h00);

        for (int off = 0; off < 8; off++) begin
            int c;
            c = chan_of(off);
            if (c >= 0) begin
                wr_page(0, off, 8'h10 + 8'(off) * 8'h11);
                exp_lo[c] = 8'h10 + 8'(off) * 8'h11;
                wr_page(1, off, 8'h80 | (8'h05 + 8'(off) * 8'h0D));
                exp_hi[c] = 8'h80 | (8'h05 + 8'(off) * 8'h0D);
            end
        end
        check_all_pages("R2");
        // R3: writes to holes change nothing
        foreach (exp_lo[i]) begin end
        wr_page(0, 0, 8'hAA); wr_page(1, 4, 8'hBB);
        wr_page(0, 5, 8'hCC); wr_page(1, 6, 8'hDD);
        wr_page(1, 0, 8'hEE); wr_page(0, 4, 8'h99);
        check_all_pages("R3");
        // R5: rewrite the low page only
        wr_page(0, 3, 8'h5A);
        exp_lo[1] = 8'h5A;
        check_all_pages("R5");

        for (int c = 0; c < 4; c++) begin
            for (int bi = 0; bi < 4; bi++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    for (int dir = 0; dir < 2; dir++) begin
                        for (int k = 0; k < 3; k++) begin
                            logic [15:0] b, p, o;
                            logic [7:0]  m;
                            logic [30:0] e;
                            b = (bi == 0) ? 16'h0000 : (bi == 1) ? 16'h8000 :
                                (bi == 2) ? 16'hFFFF : 16'h1234;
                            p = (pi == 0) ? 16'h0000 : (pi == 1) ? 16'h0001 :
                                (pi == 2) ? 16'h0005 : 16'hFFFF;
                            m = 8'((dir << 5) | (k << 2) | c | ((k == 1) ? 8'h40 : 8'h00));
                            @(negedge clk);
                            beat_req = 1; beat_chan = 2'(c); beat_mode = m;
                            beat_base = b; beat_pos = p;
                            o = (dir != 0) ? 16'(b - p) : 16'(b + p);
                            e = {exp_hi[c][6:0], exp_lo[c], o};
                            @(negedge clk);
                            check("R10 valid after req", out_valid, 1'b1);
                            if (dir != 0) check("R6 R8 decrement address", out_phys, e);
                            else          check("R6 R7 increment address", out_phys, e);
                            check("R9 suppress flag", out_suppress, (k == 0));
                            beat_req = 0;
                        end
                    end
                end
                @(negedge clk);
                check("R10 valid drops", out_valid, 1'b0);
                check("R9 suppress idle", out_suppress, 1'b0);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule